// File: doc/BRIEF.md
# Multi-Valued Falling-Phase Edge Register

This block stores one radix-r digit. Its clock is also a radix-r digit, called the digit clock. The digit clock has two special values: a supremum digit and an infimum digit. A capture happens only when the digit clock moves from the supremum digit directly to the infimum digit. At that moment a primary stage takes the data digit together with its complement image, and a secondary stage takes the same value. For the rest of the infimum phase the primary stage stays locked, so later changes on the data input cannot reach the stored digit. When the digit clock returns to the supremum digit, the primary stage drops its temporary contents and only the secondary stage keeps the value.

The digit clock and every other input are sampled on an ordinary binary system clock. A three-valued control digit can force the stored value in two ways. Set forces the infimum digit onto the true output. Clear forces the supremum digit onto the true output. Both act on the next system clock edge, whatever the phase of the digit clock, and both override a capture in the same cycle. The complement output always shows the image of the true output. The image swaps the supremum and infimum digits and leaves every other digit unchanged.

Top module: `mvr_edge_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, the register enters the Clear state: `q` equals the supremum digit (default 0) and `q_bar` equals the infimum digit (default 2).
- R2: If `dclk` is sampled at the supremum digit on one rising edge and at the infimum digit on the next, and `isc` is not a force code, then after that second edge `q` equals the value of `d` sampled at that edge.
- R3: `q_bar` is always the image of `q`. The image maps the supremum digit to the infimum digit, maps the infimum digit to the supremum digit, and returns every other digit unchanged.
- R4: While `dclk` stays at the infimum digit after a capture, changes on `d` leave `q` and `q_bar` unchanged.
- R5: While `dclk` is at the supremum digit and `isc` is not a force code, `q` and `q_bar` hold their value for any `d`.
- R6: Any other pair of consecutive `dclk` samples causes no capture. This covers moves from a non-supremum digit to the infimum digit, moves from the supremum digit to a digit other than the infimum digit, and a return to the infimum digit that does not pass through the supremum digit.
- R7: `isc` equal to the Set code (default 1) at a rising edge makes `q` equal the infimum digit and `q_bar` equal the supremum digit after that edge. This applies at any digit clock phase and overrides a capture in the same cycle.
- R8: `isc` equal to the Clear code (default 2) at a rising edge makes `q` equal the supremum digit and `q_bar` equal the infimum digit after that edge. This applies at any digit clock phase and overrides a capture in the same cycle.
- R9: `isc` values other than the Set and Clear codes are idle. With the defaults these are 0 and 3. An idle `isc` neither forces the register nor blocks a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| rst_n | input | 1 | Synchronous active-low reset (to the Clear state) |
| dclk | input | DW | Digit clock (radix-r) |
| d | input | DW | Data digit |
| isc | input | DW | Idle/Set/Clear control digit |
| q | output | DW | Stored digit |
| q_bar | output | DW | Image of the stored digit |

## Verification
The bench applies every ordered pair of digit clock samples with every data digit. Before each pair it forces a known state, so it can tell a real capture from a missed or spurious one. A design that detects the edge on the wrong pair, or on any move into the infimum digit, would load data where the expected value is the forced state. After a capture the bench walks the data through every digit during the infimum phase, and again through a detour to a third digit and back. A design without the data lock would follow the data there. The bench also fires Set and Clear on the same cycle as a capture edge, and feeds the unused control code during a capture. A design with the wrong priority would show the data digit where the forced digit is expected, and a design that decodes the spare code would fail to capture.

// File: rtl/mvr_pkg.sv
// Shared types for the multi-valued edge register.
// Assumes: the control digit is decoded into one of three commands.
package mvr_pkg;

    // Decoded control command
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_SET   = 2'd1,
        CMD_CLEAR = 2'd2
    } mvr_cmd_e;

endpackage

// File: rtl/mvr_clk_edge.sv
// Samples the digit clock on the system clock and flags the active
// supremum-to-infimum transition. Also reports the supremum phase.
// Assumes: the digit clock is stable around system clock edges.
module mvr_clk_edge #(
    parameter int RADIX = 4,
    parameter int SUP   = 0,
    parameter int INF   = 2,
    localparam int DW   = (RADIX > 2) ? $clog2(RADIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dclk,
    output logic          fall_edge,
    output logic          at_sup
);

    localparam logic [DW-1:0] SUP_D = DW'(SUP);
    localparam logic [DW-1:0] INF_D = DW'(INF);

    logic [DW-1:0] dclk_q;

    // Remember the previous digit clock sample; reset to infimum so no false edge
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_q <= INF_D;
        else        dclk_q <= dclk;
    end

    // Edge and phase decode
    always_comb begin
        fall_edge = (dclk_q == SUP_D) && (dclk == INF_D);
        at_sup    = (dclk == SUP_D);
    end

    // R6: an edge only follows a supremum sample
    p_edge_after_sup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_edge |-> ($past(dclk) == SUP_D));

    // R6: no edge for any other sample pair once out of reset
    p_no_other_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (($past(dclk) != SUP_D) || (dclk != INF_D))) |-> !fall_edge);

endmodule

// File: rtl/mvr_isc_decode.sv
// Decodes the three-valued control digit into a command.
// Assumes: any code that is neither Set nor Clear is idle.
module mvr_isc_decode
    import mvr_pkg::*;
#(
    parameter int DW       = 2,
    parameter int SET_CODE = 1,
    parameter int CLR_CODE = 2
) (
    input  logic [DW-1:0] isc,
    output mvr_cmd_e      cmd
);

    localparam logic [DW-1:0] SET_D = DW'(SET_CODE);
    localparam logic [DW-1:0] CLR_D = DW'(CLR_CODE);

    // Map the control digit to a command (R9: others are idle)
    always_comb begin
        if (isc == SET_D)      cmd = CMD_SET;
        else if (isc == CLR_D) cmd = CMD_CLEAR;
        else                   cmd = CMD_IDLE;
    end

endmodule

// File: rtl/mvr_primary.sv
// Primary (temporary) stage: at the active edge it captures the data digit
// and its image, then stays locked until the digit clock returns to the
// supremum, where its contents are discarded. It offers the captured pair
// to the secondary stage in the edge cycle.
// Assumes: fall_edge and at_sup come from mvr_clk_edge.
module mvr_primary #(
    parameter int RADIX = 4,
    parameter int SUP   = 0,
    parameter int INF   = 2,
    localparam int DW   = (RADIX > 2) ? $clog2(RADIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fall_edge,
    input  logic          at_sup,
    input  logic [DW-1:0] d,
    output logic          xfer_en,
    output logic [DW-1:0] xfer_d,
    output logic [DW-1:0] xfer_img
);

    localparam logic [DW-1:0] SUP_D = DW'(SUP);
    localparam logic [DW-1:0] INF_D = DW'(INF);

    // Image: swap supremum and infimum, keep other digits
    function automatic logic [DW-1:0] img(input logic [DW-1:0] x);
        if (x == SUP_D)      return INF_D;
        else if (x == INF_D) return SUP_D;
        else                 return x;
    endfunction

    logic          hold_v;
    logic [DW-1:0] hold_d;
    logic [DW-1:0] hold_img;

    // Capture at the edge, lock through infimum phase, discard at supremum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v   <= 1'b0;
            hold_d   <= INF_D;
            hold_img <= SUP_D;
        end else if (at_sup) begin
            hold_v   <= 1'b0;
            hold_d   <= INF_D;
            hold_img <= SUP_D;
        end else if (fall_edge) begin
            hold_v   <= 1'b1;
            hold_d   <= d;
            hold_img <= img(d);
        end
    end

    // Present the pair being captured to the secondary stage
    always_comb begin
        xfer_en  = fall_edge;
        xfer_d   = fall_edge ? d      : hold_d;
        xfer_img = fall_edge ? img(d) : hold_img;
    end

    // R4: a locked primary pair never changes
    p_primary_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold_v) && hold_v) |-> ($stable(hold_d) && $stable(hold_img)));

    // R3: held pair is image-consistent
    p_primary_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v |-> (img(hold_img) == hold_d));

    // R5: supremum phase empties the primary stage
    p_primary_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(at_sup)) |-> !hold_v);

endmodule

// File: rtl/mvr_secondary.sv
// Secondary (permanent) stage: keeps the stored digit and its image.
// It loads the pair from the primary stage at the edge, and the Set and
// Clear commands force it at any phase, ahead of a capture.
// Assumes: cmd comes from mvr_isc_decode.
module mvr_secondary
    import mvr_pkg::*;
#(
    parameter int RADIX = 4,
    parameter int SUP   = 0,
    parameter int INF   = 2,
    localparam int DW   = (RADIX > 2) ? $clog2(RADIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mvr_cmd_e      cmd,
    input  logic          xfer_en,
    input  logic [DW-1:0] xfer_d,
    input  logic [DW-1:0] xfer_img,
    output logic [DW-1:0] q,
    output logic [DW-1:0] q_bar
);

    localparam logic [DW-1:0] SUP_D = DW'(SUP);
    localparam logic [DW-1:0] INF_D = DW'(INF);

    // Image used by the checks only
    function automatic logic [DW-1:0] img(input logic [DW-1:0] x);
        if (x == SUP_D)      return INF_D;
        else if (x == INF_D) return SUP_D;
        else                 return x;
    endfunction

    // Force commands first, then the transfer from the primary stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= SUP_D;
            q_bar <= INF_D;
        end else begin
            unique case (cmd)
                CMD_SET: begin
                    q     <= INF_D;
                    q_bar <= SUP_D;
                end
                CMD_CLEAR: begin
                    q     <= SUP_D;
                    q_bar <= INF_D;
                end
                default: begin
                    if (xfer_en) begin
                        q     <= xfer_d;
                        q_bar <= xfer_img;
                    end
                end
            endcase
        end
    end

    // R7: Set forces infimum on q
    p_set_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_SET) |=> ((q == INF_D) && (q_bar == SUP_D)));

    // R8: Clear forces supremum on q
    p_clear_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CLEAR) |=> ((q == SUP_D) && (q_bar == INF_D)));

    // R2: idle transfer loads the offered digit
    p_capture_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_IDLE) && xfer_en) |=> (q == $past(xfer_d)));

    // R5: nothing moves without a transfer or force
    p_hold_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_IDLE) && !xfer_en) |=> ($stable(q) && $stable(q_bar)));

    // R3: the two outputs stay image-related
    p_qbar_image_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_bar == img(q));

endmodule

// File: rtl/mvr_edge_reg.sv
// Top level: multi-valued register clocked on the supremum-to-infimum
// transition of a digit clock, with a locked primary stage, a permanent
// secondary stage and a three-valued Set/Clear control.
// Assumes: all inputs are synchronous to clk; RADIX >= 3 so the three
// control codes can be distinct.
module mvr_edge_reg
    import mvr_pkg::*;
#(
    parameter int RADIX     = 4,
    parameter int SUP_DIGIT = 0,
    parameter int INF_DIGIT = 2,
    parameter int SET_CODE  = 1,
    parameter int CLR_CODE  = 2,
    localparam int DW       = (RADIX > 2) ? $clog2(RADIX) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] dclk,
    input  logic [DW-1:0] d,
    input  logic [DW-1:0] isc,
    output logic [DW-1:0] q,
    output logic [DW-1:0] q_bar
);

    // Parameter sanity at elaboration
    generate
        if (SUP_DIGIT == INF_DIGIT || SET_CODE == CLR_CODE || RADIX < 3) begin : g_bad_cfg
            initial $error("mvr_edge_reg: inconsistent digit parameters");
        end
    endgenerate

    logic          fall_edge;
    logic          at_sup;
    logic          xfer_en;
    logic [DW-1:0] xfer_d;
    logic [DW-1:0] xfer_img;
    mvr_cmd_e      cmd;

    mvr_clk_edge #(.RADIX(RADIX), .SUP(SUP_DIGIT), .INF(INF_DIGIT)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .dclk      (dclk),
        .fall_edge (fall_edge),
        .at_sup    (at_sup)
    );

    mvr_isc_decode #(.DW(DW), .SET_CODE(SET_CODE), .CLR_CODE(CLR_CODE)) u_dec (
        .isc (isc),
        .cmd (cmd)
    );

    mvr_primary #(.RADIX(RADIX), .SUP(SUP_DIGIT), .INF(INF_DIGIT)) u_pri (
        .clk       (clk),
        .rst_n     (rst_n),
        .fall_edge (fall_edge),
        .at_sup    (at_sup),
        .d         (d),
        .xfer_en   (xfer_en),
        .xfer_d    (xfer_d),
        .xfer_img  (xfer_img)
    );

    mvr_secondary #(.RADIX(RADIX), .SUP(SUP_DIGIT), .INF(INF_DIGIT)) u_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .xfer_en  (xfer_en),
        .xfer_d   (xfer_d),
        .xfer_img (xfer_img),
        .q        (q),
        .q_bar    (q_bar)
    );

    // R4: staying in infimum with idle control keeps q
    p_infimum_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (dclk == DW'(INF_DIGIT)) && ($past(dclk) == DW'(INF_DIGIT))
         && (isc != DW'(SET_CODE)) && (isc != DW'(CLR_CODE)))
        |=> $stable(q));

endmodule

// File: tb/mvr_edge_reg_tb.sv
module mvr_edge_reg_tb;

    localparam int SUP = 0;
    localparam int INF = 2;
    localparam int SETC = 1;
    localparam int CLRC = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] dclk = 2'(INF);
    logic [1:0] d = 2'd0;
    logic [1:0] isc = 2'd0;
    logic [1:0] q;
    logic [1:0] q_bar;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mvr_edge_reg u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .dclk  (dclk),
        .d     (d),
        .isc   (isc),
        .q     (q),
        .q_bar (q_bar)
    );

    function automatic int img(input int x);
        if (x == SUP) return INF;
        if (x == INF) return SUP;
        return x;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int exp_q);
        int exp_qb;
        exp_qb = img(exp_q);
        n_chk++;
        if (int'(q) != exp_q || int'(q_bar) != exp_qb) begin
            n_bad++;
            $display("FAIL %s: q=%0d q_bar=%0d expected q=%0d q_bar=%0d",
                     req, q, q_bar, exp_q, exp_qb);
        end
    endtask

    task automatic drive(input int c, input int dv, input int ic);
        dclk = 2'(c);
        d    = 2'(dv);
        isc  = 2'(ic);
    endtask

    initial begin
        tick();
        // R1: reset state
        drive(INF, 3, 0);
        tick(); tick(); tick();
        chk("R1 reset", SUP);
        rst_n = 1'b1;

        // R2/R6/R3/R7/R8: every clock pair x every data digit
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 4; c++) begin
                for (int dv = 0; dv < 4; dv++) begin
                    int pre_code;
                    int pre_q;
                    int exp_q;
                    pre_code = dv[0] ? SETC : CLRC;
                    pre_q    = dv[0] ? INF  : SUP;
                    drive(p, (dv + 1) % 4, pre_code);
                    tick();
                    drive(c, dv, 0);
                    tick();
                    exp_q = (p == SUP && c == INF) ? dv : pre_q;
                    chk((p == SUP && c == INF) ? "R2 capture" : "R6 no capture", exp_q);
                end
            end
        end

        // R4: data lock during infimum phase
        drive(SUP, 0, CLRC); tick();
        drive(INF, 3, 0);    tick();
        chk("R2 capture 3", 3);
        for (int k = 0; k < 4; k++) begin
            drive(INF, k, 0); tick();
            chk("R4 locked in infimum", 3);
        end
        // R6: infimum -> other -> infimum without supremum
        drive(1, 1, 0);   tick(); chk("R6 detour digit", 3);
        drive(INF, 1, 0); tick(); chk("R6 return to infimum", 3);

        // R5: supremum phase holds
        for (int k = 0; k < 4; k++) begin
            drive(SUP, k, 0); tick();
            chk("R5 hold at supremum", 3);
        end
        drive(INF, 1, 0); tick();
        chk("R2 recapture after supremum", 1);

        // R7: Set overrides a capture edge
        drive(SUP, 3, 0);    tick();
        drive(INF, 3, SETC); tick();
        chk("R7 set over edge", INF);
        // R8: Clear overrides a capture edge
        drive(SUP, 3, 0);    tick();
        drive(INF, 3, CLRC); tick();
        chk("R8 clear over edge", SUP);
        // R7: Set in the middle of an infimum phase
        drive(INF, 1, SETC); tick();
        chk("R7 set in infimum", INF);
        // R8: Clear during a supremum phase
        drive(SUP, 1, CLRC); tick();
        chk("R8 clear at supremum", SUP);

        // R9: spare code 3 is idle
        drive(SUP, 3, 3); tick();
        chk("R9 spare code holds", SUP);
        drive(INF, 3, 3); tick();
        chk("R9 spare code captures", 3);
        drive(INF, 0, 3); tick();
        chk("R9 spare code keeps lock", 3);

        // R1: reset in mid-run
        rst_n = 1'b0; drive(INF, 1, 0); tick();
        chk("R1 reset mid-run", SUP);
        rst_n = 1'b1; tick();
        chk("R6 no edge after reset", SUP);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule